// File: doc/BRIEF.md
# Spindle Speed Regulator

This block closes the speed loop of a sensorless spindle motor in digital logic. It times the spacing between rising edges of the motor's frequency-generator pulse train with a saturating cycle counter, compares that period with a programmable target period, and drives a speed-control PWM. The PWM's duty sets the spindle current once it is filtered outside the block. For a three-phase motor the pulse rate is rpm × poles / 2 × 3 / 60. For example, an 8-pole motor at 5400 rpm gives 1080 Hz, which is about 92 600 cycles of a 100 MHz clock. `CNT_W` must therefore be sized for the slowest speed to be measured.

While the motor is well below speed, the PWM stays at full duty. Once the period comes close to the target, a signed proportional term on the period error sets the duty. The duty never drops below a floor of about 13 % of full scale, because below that level the power stage delivers no current. A running flag is raised after a run of consecutive measurements that fall within ±1 % of the target. An actuator-enable flag follows after a further programmable delay, about 100 ms at the default setting. If the pulse train stops, the measurement saturates, the running flag drops and the duty returns to full scale. When spindle-enable is low, the PWM is held low and both flags are cleared.

Top module: `spindle_speed_ctrl`

## Requirements
- R1: `period_out` equals the number of clock cycles between successive rising edges of `fg_in`, as seen through a two-stage synchroniser, and changes only when a new measurement completes. It is all ones after reset and while `spin_en` is low.
- R2: If no rising edge arrives before the counter reaches 2^CNT_W − 1, `period_out` goes to all ones, `running` clears and the duty returns to full scale (2^DUTY_W − 1).
- R3: `running` sets on the RUN_COUNT-th consecutive measurement that is in the window. A measurement is in the window when 100 · |period − target| ≤ target.
- R4: `running` clears on the first measurement that is out of the window.
- R5: `vcm_en` rises exactly VCM_DELAY cycles after `running` rises, is never high while `running` is low, and falls in the same cycle as `running`.
- R6: A measurement that exceeds the target by more than target >> NEAR_SHIFT (motor too slow) sets the duty to full scale, so the PWM stays high.
- R7: A measurement that falls short of the target by more than target >> NEAR_SHIFT (motor too fast) sets the duty to the floor, round(13 % of full scale), which is 33 for 8-bit duty.
- R8: Within the near band, the duty equals BASE_DUTY + ((period − target) · kp_gain >>> KP_SHIFT), clamped to the range from the floor to full scale. `kp_gain` is a two's-complement value.
- R9: The PWM carrier period is (2^DUTY_W − 1) · PRESCALE cycles, and `pwm_out` is high for duty · PRESCALE cycles of each period.
- R10: While `spin_en` is low, `pwm_out` is low, both flags are clear and the duty is reset to full scale, so the next start begins at full drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| fg_in | input | 1 | Frequency-generator pulse train from the motor (asynchronous) |
| spin_en | input | 1 | Spindle enable |
| target_period | input | CNT_W | Target FG period in clock cycles |
| kp_gain | input | GAIN_W | Signed proportional gain |
| pwm_out | output | 1 | Speed-control PWM |
| period_out | output | CNT_W | Last measured FG period in clock cycles |
| running | output | 1 | Speed has stayed within ±1 % of the target |
| vcm_en | output | 1 | Delayed actuator enable |

## Verification
The assertions check the following on every cycle: a disabled PWM is low, full duty means a constant high output, `vcm_en` implies `running`, and `vcm_en` rises exactly VCM_DELAY cycles into a running stretch. They also check that a timeout forces full duty and drops `running`, that the duty never falls below the floor, and that the period output holds between measurements. Only the bench's scenarios can show the remaining behaviour. That covers the exact ±1 % window arithmetic, the count of consecutive in-window periods, the duty values in the slow, fast, proportional and clamped cases, and the high time per carrier period. It also covers recovery after a stall and after disable.

// File: rtl/spd_pkg.sv
`timescale 1ns/1ps
package spd_pkg;
  // fraction scale used for window and dead-zone arithmetic
  localparam int PCT_SCALE    = 100;
  localparam int WINDOW_PCT   = 1;
  localparam int DEADZONE_PCT = 13;

  // rounded duty code below which the power stage delivers no current
  function automatic int floor_code(input int duty_w);
    return (((2 ** duty_w) - 1) * DEADZONE_PCT + PCT_SCALE / 2) / PCT_SCALE;
  endfunction
endpackage

// File: rtl/spd_fg_meter.sv
`timescale 1ns/1ps
module spd_fg_meter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             fg_in,
  output logic [CNT_W-1:0] period_q,
  output logic             valid_q,
  output logic             tout_q
);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_MAX - 1'b1;

  logic [2:0]       sync_q;
  logic [CNT_W-1:0] cnt_q;
  logic             rise;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[1:0], fg_in};
  end

  assign rise = sync_q[1] & ~sync_q[2];

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt_q    <= '0;
      period_q <= CNT_MAX;
      valid_q  <= 1'b0;
      tout_q   <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      tout_q  <= 1'b0;
      if (rise) begin
        period_q <= cnt_q;
        cnt_q    <= {{(CNT_W-1){1'b0}}, 1'b1};
        valid_q  <= 1'b1;
      end else if (cnt_q == CNT_LAST) begin
        cnt_q    <= CNT_MAX;
        period_q <= CNT_MAX;
        valid_q  <= 1'b1;
        tout_q   <= 1'b1;
      end else if (cnt_q != CNT_MAX) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R1: the measurement only moves when a new period is reported
  assert_period_hold_R1: assert property (@(posedge clk) disable iff (rst)
    ($past(en) && !valid_q) |-> $stable(period_q));
endmodule

// File: rtl/spd_run_qual.sv
`timescale 1ns/1ps
module spd_run_qual #(
  parameter int CNT_W     = 16,
  parameter int RUN_COUNT = 8,
  parameter int VCM_DELAY = 1000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             valid,
  input  logic             tout,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] target,
  output logic             running_q,
  output logic             vcm_q
);
  import spd_pkg::*;
  localparam int RC_W  = $clog2(RUN_COUNT + 1);
  localparam int DL_W  = $clog2(VCM_DELAY + 1);
  localparam int AGE_W = DL_W + 1;
  localparam int WIDE  = CNT_W + 7;

  logic [CNT_W-1:0] diff;
  logic [WIDE-1:0]  scaled_diff;
  logic             in_win;
  logic [RC_W-1:0]  run_cnt_q, run_nxt;
  logic             run_d;
  logic [DL_W-1:0]  dly_q;

  assign diff        = (period >= target) ? (period - target) : (target - period);
  assign scaled_diff = WIDE'(diff) * WIDE'(PCT_SCALE / WINDOW_PCT);
  assign in_win      = scaled_diff <= WIDE'(target);

  always_comb begin
    run_nxt = run_cnt_q;
    run_d   = running_q;
    if (valid) begin
      if (in_win && !tout) begin
        run_nxt = (run_cnt_q == RC_W'(RUN_COUNT)) ? run_cnt_q : run_cnt_q + 1'b1;
        run_d   = (run_nxt == RC_W'(RUN_COUNT));
      end else begin
        run_nxt = '0;
        run_d   = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      run_cnt_q <= '0;
      running_q <= 1'b0;
      dly_q     <= '0;
      vcm_q     <= 1'b0;
    end else begin
      run_cnt_q <= run_nxt;
      running_q <= run_d;
      if (!run_d) begin
        dly_q <= '0;
        vcm_q <= 1'b0;
      end else if (running_q) begin
        if (dly_q == DL_W'(VCM_DELAY - 1)) vcm_q <= 1'b1;
        else                               dly_q <= dly_q + 1'b1;
      end
    end
  end

  // checker: cycles spent in the running state
  logic [AGE_W-1:0] age_q;
  always_ff @(posedge clk) begin
    if (rst || !running_q)            age_q <= '0;
    else if (age_q != {AGE_W{1'b1}})  age_q <= age_q + 1'b1;
  end

  assert_vcm_needs_run_R5: assert property (@(posedge clk) disable iff (rst)
    vcm_q |-> running_q);
  assert_vcm_after_delay_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(vcm_q) |-> (age_q == AGE_W'(VCM_DELAY)));
  assert_run_from_meas_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(running_q) |-> $past(valid));
  assert_stall_drops_run_R2: assert property (@(posedge clk) disable iff (rst)
    tout |=> !running_q);
endmodule

// File: rtl/spd_duty_ctrl.sv
`timescale 1ns/1ps
module spd_duty_ctrl #(
  parameter int CNT_W      = 16,
  parameter int GAIN_W     = 8,
  parameter int DUTY_W     = 8,
  parameter int KP_SHIFT   = 4,
  parameter int NEAR_SHIFT = 3,
  parameter int FLOOR_DUTY = 33,
  parameter int BASE_DUTY  = 128
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     en,
  input  logic                     valid,
  input  logic                     tout,
  input  logic [CNT_W-1:0]         period,
  input  logic [CNT_W-1:0]         target,
  input  logic signed [GAIN_W-1:0] kp,
  output logic [DUTY_W-1:0]        duty_q
);
  localparam int E_W = CNT_W + 1;
  localparam int P_W = E_W + GAIN_W;
  localparam int S_W = P_W + 2;
  localparam logic [DUTY_W-1:0] FULL_V  = '1;
  localparam logic [DUTY_W-1:0] FLOOR_V = DUTY_W'(FLOOR_DUTY);

  logic signed [E_W-1:0] err;
  logic [CNT_W-1:0]      mag;
  logic                  near;
  logic signed [P_W-1:0] prod;
  logic signed [S_W-1:0] sum_s, floor_s, full_s;
  logic [DUTY_W-1:0]     reg_duty;

  assign err     = $signed({1'b0, period}) - $signed({1'b0, target});
  assign mag     = err[E_W-1] ? CNT_W'(-err) : CNT_W'(err);
  assign near    = mag <= (target >> NEAR_SHIFT);
  assign prod    = P_W'(err) * P_W'(kp);
  assign sum_s   = S_W'(BASE_DUTY) + S_W'(prod >>> KP_SHIFT);
  assign floor_s = S_W'(FLOOR_DUTY);
  assign full_s  = S_W'((2 ** DUTY_W) - 1);

  always_comb begin
    if (sum_s < floor_s)     reg_duty = FLOOR_V;
    else if (sum_s > full_s) reg_duty = FULL_V;
    else                     reg_duty = sum_s[DUTY_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      duty_q <= FULL_V;
    end else if (valid) begin
      if (tout)       duty_q <= FULL_V;
      else if (!near) duty_q <= err[E_W-1] ? FLOOR_V : FULL_V;
      else            duty_q <= reg_duty;
    end
  end

  assert_stall_full_R2: assert property (@(posedge clk) disable iff (rst)
    tout |=> (duty_q == FULL_V));
  assert_duty_floor_R7: assert property (@(posedge clk) disable iff (rst)
    duty_q >= FLOOR_V);
endmodule

// File: rtl/spd_pwm_gen.sv
`timescale 1ns/1ps
module spd_pwm_gen #(
  parameter int DUTY_W   = 8,
  parameter int PRESCALE = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [DUTY_W-1:0] duty,
  output logic              pwm_q
);
  localparam logic [DUTY_W-1:0] FULL_V = '1;
  localparam logic [DUTY_W-1:0] TOP_V  = FULL_V - 1'b1;
  localparam int PS_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  logic              tick;
  logic [DUTY_W-1:0] phase_q;

  generate
    if (PRESCALE > 1) begin : g_presc
      logic [PS_W-1:0] ps_q;
      assign tick = (ps_q == PS_W'(PRESCALE - 1));
      always_ff @(posedge clk) begin
        if (rst || tick) ps_q <= '0;
        else             ps_q <= ps_q + 1'b1;
      end
    end else begin : g_direct
      assign tick = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
      pwm_q   <= 1'b0;
    end else begin
      if (tick) phase_q <= (phase_q == TOP_V) ? '0 : phase_q + 1'b1;
      pwm_q <= en && (phase_q < duty);
    end
  end

  assert_off_low_R10: assert property (@(posedge clk) disable iff (rst)
    !en |=> !pwm_q);
  assert_full_high_R6: assert property (@(posedge clk) disable iff (rst)
    (en && duty == FULL_V) |=> pwm_q);
endmodule

// File: rtl/spindle_speed_ctrl.sv
`timescale 1ns/1ps
module spindle_speed_ctrl #(
  parameter int CNT_W      = 16,
  parameter int GAIN_W     = 8,
  parameter int DUTY_W     = 8,
  parameter int PRESCALE   = 4,
  parameter int RUN_COUNT  = 8,
  parameter int VCM_DELAY  = 10_000_000,
  parameter int KP_SHIFT   = 4,
  parameter int NEAR_SHIFT = 3,
  parameter int BASE_DUTY  = 128
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     fg_in,
  input  logic                     spin_en,
  input  logic [CNT_W-1:0]         target_period,
  input  logic signed [GAIN_W-1:0] kp_gain,
  output logic                     pwm_out,
  output logic [CNT_W-1:0]         period_out,
  output logic                     running,
  output logic                     vcm_en
);
  localparam int FLOOR_DUTY = spd_pkg::floor_code(DUTY_W);

  logic              meas_valid, meas_tout;
  logic [DUTY_W-1:0] duty;

  spd_fg_meter #(.CNT_W(CNT_W)) i_meter (
    .clk(clk), .rst(rst), .en(spin_en), .fg_in(fg_in),
    .period_q(period_out), .valid_q(meas_valid), .tout_q(meas_tout)
  );

  spd_run_qual #(.CNT_W(CNT_W), .RUN_COUNT(RUN_COUNT), .VCM_DELAY(VCM_DELAY)) i_qual (
    .clk(clk), .rst(rst), .en(spin_en), .valid(meas_valid), .tout(meas_tout),
    .period(period_out), .target(target_period),
    .running_q(running), .vcm_q(vcm_en)
  );

  spd_duty_ctrl #(
    .CNT_W(CNT_W), .GAIN_W(GAIN_W), .DUTY_W(DUTY_W), .KP_SHIFT(KP_SHIFT),
    .NEAR_SHIFT(NEAR_SHIFT), .FLOOR_DUTY(FLOOR_DUTY), .BASE_DUTY(BASE_DUTY)
  ) i_duty (
    .clk(clk), .rst(rst), .en(spin_en), .valid(meas_valid), .tout(meas_tout),
    .period(period_out), .target(target_period), .kp(kp_gain), .duty_q(duty)
  );

  spd_pwm_gen #(.DUTY_W(DUTY_W), .PRESCALE(PRESCALE)) i_pwm (
    .clk(clk), .rst(rst), .en(spin_en), .duty(duty), .pwm_q(pwm_out)
  );
endmodule

// File: tb/test_spindle_speed_ctrl.sv
`timescale 1ns/1ps
module test_spindle_speed_ctrl;
  localparam int CW = 12, GW = 8, DW = 8, PS = 2, RC = 8, VD = 300;
  localparam int KS = 4, NS = 3, BASE = 128;
  localparam int FULL = 255, FLOOR = 33, CMAX = 4095, CARRIER = FULL * PS;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fg_in = 1'b0;
  logic spin_en = 1'b0;
  logic [CW-1:0] target_period = 12'd1000;
  logic signed [GW-1:0] kp_gain = 8'sd4;
  logic pwm_out, running, vcm_en;
  logic [CW-1:0] period_out;

  int n_tests = 0, n_fail = 0;
  bit finished = 0, started = 0;
  int fg_per = 0, fg_cur = 0, fg_ph = 0;

  always #5 clk = ~clk;

  spindle_speed_ctrl #(
    .CNT_W(CW), .GAIN_W(GW), .DUTY_W(DW), .PRESCALE(PS), .RUN_COUNT(RC),
    .VCM_DELAY(VD), .KP_SHIFT(KS), .NEAR_SHIFT(NS), .BASE_DUTY(BASE)
  ) i_spindle_speed_ctrl (
    .clk(clk), .rst(rst), .fg_in(fg_in), .spin_en(spin_en),
    .target_period(target_period), .kp_gain(kp_gain), .pwm_out(pwm_out),
    .period_out(period_out), .running(running), .vcm_en(vcm_en)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // pulse-train source: rising edge every fg_cur cycles, half high
  always @(negedge clk) begin
    if (fg_per == 0) begin
      fg_in = 1'b0; fg_ph = 0;
    end else begin
      if (fg_ph == 0) fg_cur = fg_per;
      fg_in = (fg_ph < fg_cur / 2);
      fg_ph = (fg_ph + 1 >= fg_cur) ? 0 : fg_ph + 1;
    end
  end

  // behavioural reference model
  int s1, s2, s3, cnt, per, val, tout, rcnt, run, dly, vcm, duty, psc, ph, pwm;
  always @(posedge clk) begin
    int e, d, nr, nrun, edge_seen, npwm, dev;
    started = 1;
    if (rst) begin
      s1 = 0; s2 = 0; s3 = 0; cnt = 0; per = CMAX; val = 0; tout = 0;
      rcnt = 0; run = 0; dly = 0; vcm = 0; duty = FULL; psc = 0; ph = 0; pwm = 0;
    end else begin
      npwm = (spin_en && ph < duty) ? 1 : 0;
      if (psc == PS - 1) begin psc = 0; ph = (ph == FULL - 1) ? 0 : ph + 1; end
      else psc++;
      pwm = npwm;
      e = int'(per) - int'(target_period);
      dev = (e < 0) ? -e : e;
      if (!spin_en) duty = FULL;
      else if (val != 0) begin
        if (tout != 0) duty = FULL;
        else if (dev > int'(target_period) / 8) duty = (e > 0) ? FULL : FLOOR;
        else begin
          d = BASE + ((e * int'(kp_gain)) >>> KS);
          duty = (d < FLOOR) ? FLOOR : (d > FULL) ? FULL : d;
        end
      end
      if (!spin_en) begin rcnt = 0; run = 0; dly = 0; vcm = 0; end
      else begin
        nr = rcnt; nrun = run;
        if (val != 0) begin
          if (tout == 0 && 100 * dev <= int'(target_period)) begin
            nr = (rcnt < RC) ? rcnt + 1 : RC; nrun = (nr == RC) ? 1 : 0;
          end else begin nr = 0; nrun = 0; end
        end
        if (nrun == 0) begin dly = 0; vcm = 0; end
        else if (run != 0) begin
          if (dly == VD - 1) vcm = 1; else dly++;
        end
        rcnt = nr; run = nrun;
      end
      edge_seen = (s2 != 0 && s3 == 0) ? 1 : 0;
      s3 = s2; s2 = s1; s1 = fg_in;
      if (!spin_en) begin cnt = 0; per = CMAX; val = 0; tout = 0; end
      else begin
        val = 0; tout = 0;
        if (edge_seen != 0) begin per = cnt; cnt = 1; val = 1; end
        else if (cnt == CMAX - 1) begin cnt = CMAX; per = CMAX; val = 1; tout = 1; end
        else if (cnt != CMAX) cnt++;
      end
    end
  end

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (started && !finished) begin
      chk(period_out == per, "R1 period_out vs model", period_out, per);
      chk(running == run[0], "R3 running vs model", running, run);
      chk(vcm_en == vcm[0], "R5 vcm_en vs model", vcm_en, vcm);
      chk(pwm_out == pwm[0], "R9 pwm_out vs model", pwm_out, pwm);
    end
  end

  task automatic high_count(input string tag, input int exp);
    int hi = 0;
    for (int i = 0; i < CARRIER; i++) begin
      @(negedge clk);
      if (pwm_out) hi++;
    end
    chk(hi == exp, tag, hi, exp);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #(150000 * 10);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    wait_cyc(4);
    chk(period_out == CMAX, "R10 reset period", period_out, CMAX);
    chk(!running, "R10 reset running", running, 0);
    chk(!vcm_en, "R10 reset vcm_en", vcm_en, 0);
    chk(!pwm_out, "R10 reset pwm", pwm_out, 0);
    rst = 1'b0;

    spin_en = 1'b1; fg_per = 1000;
    wait_cyc(12000);
    chk(running, "R3 in-window run sets running", running, 1);
    chk(period_out == 1000, "R1 measured period", period_out, 1000);
    chk(vcm_en, "R5 vcm_en after delay", vcm_en, 1);
    high_count("R8 zero error gives base duty", 2 * BASE);

    fg_per = 1015;
    wait_cyc(2500);
    chk(!running, "R4 1.5% off clears running", running, 0);
    chk(!vcm_en, "R5 vcm_en falls with running", vcm_en, 0);
    chk(period_out == 1015, "R1 new period", period_out, 1015);
    high_count("R8 proportional duty", 2 * 131);

    fg_per = 1200;
    wait_cyc(2500);
    high_count("R6 slow motor full duty", CARRIER);

    fg_per = 800;
    wait_cyc(2500);
    high_count("R7 fast motor floor duty", 2 * FLOOR);

    fg_per = 1100; kp_gain = 8'sd100;
    wait_cyc(2500);
    high_count("R8 clamp at full", CARRIER);
    kp_gain = -8'sd100;
    wait_cyc(2500);
    high_count("R8 clamp at floor", 2 * FLOOR);

    kp_gain = 8'sd4; fg_per = 1000;
    wait_cyc(11000);
    chk(running, "R3 running regained", running, 1);
    fg_per = 0;
    wait_cyc(6000);
    chk(period_out == CMAX, "R2 stalled period saturates", period_out, CMAX);
    chk(!running, "R2 stall clears running", running, 0);
    high_count("R2 stall full duty", CARRIER);

    fg_per = 1000;
    wait_cyc(3000);
    spin_en = 1'b0;
    wait_cyc(3);
    chk(!pwm_out, "R10 disable pwm low", pwm_out, 0);
    chk(!running && !vcm_en, "R10 disable flags", running, 0);
    chk(period_out == CMAX, "R10 disable period", period_out, CMAX);
    high_count("R10 disabled pwm stays low", 0);
    summary();
  end
endmodule